// File: doc/BRIEF.md
# Dual-Port Address-Collision Busy Arbiter

This block sits beside a shared two-port storage array and settles what happens when both ports reach the same word at once. Each port has an active-low enable, an active-low write strobe and a 15-bit word address. While both ports are enabled and their addresses are equal, the block grants the location to one port. It drives the other port's active-low busy flag and blocks that port's write strobe before it reaches the array. Reads are never gated.

Arrival order is measured on a common clock. A port counts as settled when it was enabled on the same address at the previous clock edge. A port that has just enabled, or has just changed address, counts as new. The settled port wins against a new one. When both ports are new in the same cycle, the left port wins. A port that holds the grant keeps it for as long as its enable and address stay unchanged.

A mode input picks one of two roles. In master mode the block computes both busy flags and drives them out. In slave mode both busy outputs are held high, and externally supplied busy inputs gate the write strobes instead.

Top module: `dpram_busy_arb`

## Requirements
- R1: With the mode input high (master), when either enable is high or the two addresses differ, both busy outputs are high.
- R2: In master mode, when one port has been enabled on an address since the previous clock edge and the other port enables onto that same address (or moves its address onto it), the newcomer's busy output goes low in that same cycle and the settled port's busy output stays high.
- R3: The two busy outputs are never low at the same time.
- R4: In master mode, when both ports become enabled on the same address in the same cycle, the right busy output goes low and the left busy output stays high.
- R5: In master mode, a port holding the grant keeps it while its enable stays low and its address stays unchanged, even after the losing port has itself become settled. When the winner's enable goes high, both busy outputs return high.
- R6: In master mode, a port's array write strobe is high while that port's busy output is low, whatever its write input is. Otherwise the array write strobe equals the port's write input.
- R7: With the mode input low (slave), both busy outputs are held high. Each array write strobe is forced high while that port's busy input is low, and equals the port's write input while the busy input is high.
- R8: After synchronous reset, no port counts as settled. A collision that appears in the first cycle after reset goes to the left port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = compute and drive busy, 0 = take busy from inputs |
| l_ce_n | input | 1 | Left port enable, active low |
| l_we_n | input | 1 | Left port write strobe, active low |
| l_addr | input | 15 | Left port word address |
| r_ce_n | input | 1 | Right port enable, active low |
| r_we_n | input | 1 | Right port write strobe, active low |
| r_addr | input | 15 | Right port word address |
| l_busy_in_n | input | 1 | Left busy input used in slave mode, active low |
| r_busy_in_n | input | 1 | Right busy input used in slave mode, active low |
| l_busy_n | output | 1 | Left busy output, active low |
| r_busy_n | output | 1 | Right busy output, active low |
| l_arr_we_n | output | 1 | Gated left write strobe to the array |
| r_arr_we_n | output | 1 | Gated right write strobe to the array |

## Verification
Arbitration and write suppression can act in the same cycle. A port can present a write in the very cycle it loses a collision, and its strobe must then be blocked at once. The bench provokes this by sweeping every enable combination over a small set of address pairs. In each step both ports arrive together with their writes asserted, and the bench compares busy flags and gated strobes against values worked out from the first-arrival and left-wins rules. Directed sequences then add staggered arrivals, grant holding, release and slave mode.

// File: rtl/dparb_pkg.sv
package dparb_pkg;

    parameter int AW = 15;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
    } port_s;

    function automatic logic collide(input port_s a, input port_s b);
        return a.en && b.en && (a.addr == b.addr);
    endfunction

endpackage

// File: rtl/dparb_port_track.sv
module dparb_port_track
    import dparb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  port_s cur,
    output logic  settled
);

    port_s prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= cur;
        end
    end

    assign settled = cur.en && prev_q.en && (prev_q.addr == cur.addr);

endmodule

// File: rtl/dparb_grant.sv
module dparb_grant
    import dparb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  port_s  lp,
    input  port_s  rp,
    input  logic   l_settled,
    input  logic   r_settled,
    output owner_e grant
);

    owner_e owner_q;
    logic   hit;

    assign hit = collide(lp, rp);

    always_comb begin
        if (!hit) begin
            grant = OWN_NONE;
        end else if (owner_q == OWN_LEFT && l_settled) begin
            grant = OWN_LEFT;
        end else if (owner_q == OWN_RIGHT && r_settled) begin
            grant = OWN_RIGHT;
        end else if (r_settled && !l_settled) begin
            grant = OWN_RIGHT;
        end else begin
            grant = OWN_LEFT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OWN_NONE;
        end else begin
            owner_q <= grant;
        end
    end

    // R2: a settled port facing a newcomer is never the loser
    a_r2_settled_wins: assert property (@(posedge clk) disable iff (rst)
        (hit && l_settled && !r_settled) |-> (grant == OWN_LEFT));

endmodule

// File: rtl/dparb_wgate.sv
module dparb_wgate (
    input  logic clk,
    input  logic rst,
    input  logic master,
    input  logic lose,
    input  logic busy_in_n,
    input  logic we_n,
    output logic busy_out_n,
    output logic arr_we_n
);

    logic inhibit;

    assign busy_out_n = master ? !lose : 1'b1;
    assign inhibit    = master ? lose : !busy_in_n;
    assign arr_we_n   = we_n | inhibit;

    // R6: a port shown as busy never reaches the array with a write
    a_r6_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        !busy_out_n |-> arr_we_n);

    // R7: in slave mode the external busy input blocks the write
    a_r7_slave_block: assert property (@(posedge clk) disable iff (rst)
        (!master && !busy_in_n) |-> arr_we_n);

endmodule

// File: rtl/dpram_busy_arb.sv
module dpram_busy_arb
    import dparb_pkg::*;
#(
    parameter int ADDR_W = dparb_pkg::AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              l_ce_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_ce_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_arr_we_n,
    output logic              r_arr_we_n
);

    port_s  lp, rp;
    logic   l_set, r_set;
    owner_e grant;
    logic   l_lose, r_lose;
    logic   past_ok;

    assign lp = '{en: !l_ce_n, addr: l_addr};
    assign rp = '{en: !r_ce_n, addr: r_addr};

    dparb_port_track u_trk_l (.clk(clk), .rst(rst), .cur(lp), .settled(l_set));
    dparb_port_track u_trk_r (.clk(clk), .rst(rst), .cur(rp), .settled(r_set));

    dparb_grant u_grant (
        .clk(clk), .rst(rst), .lp(lp), .rp(rp),
        .l_settled(l_set), .r_settled(r_set), .grant(grant)
    );

    assign l_lose = (grant == OWN_RIGHT);
    assign r_lose = (grant == OWN_LEFT);

    dparb_wgate u_gate_l (
        .clk(clk), .rst(rst), .master(master_mode), .lose(l_lose),
        .busy_in_n(l_busy_in_n), .we_n(l_we_n),
        .busy_out_n(l_busy_n), .arr_we_n(l_arr_we_n)
    );

    dparb_wgate u_gate_r (
        .clk(clk), .rst(rst), .master(master_mode), .lose(r_lose),
        .busy_in_n(r_busy_in_n), .we_n(r_we_n),
        .busy_out_n(r_busy_n), .arr_we_n(r_arr_we_n)
    );

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R3: never both busy at once
    a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!l_busy_n && !r_busy_n));

    // R1: no collision means no busy
    a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
        (l_ce_n || r_ce_n || (l_addr != r_addr)) |-> (l_busy_n && r_busy_n));

    // R5: right loser stays busy while both ports hold still
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (past_ok && master_mode && $past(master_mode) && !$past(r_busy_n)
         && !l_ce_n && !r_ce_n && !$past(l_ce_n) && !$past(r_ce_n)
         && (l_addr == $past(l_addr)) && (r_addr == $past(r_addr))
         && (l_addr == r_addr)) |-> !r_busy_n);

    // R7: slave mode never drives busy low
    a_r7_slave_quiet: assert property (@(posedge clk) disable iff (rst)
        !master_mode |-> (l_busy_n && r_busy_n));

endmodule

// File: tb/dpram_busy_arb_tb.sv
module dpram_busy_arb_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        master_mode = 1'b1;
    logic        l_ce_n = 1'b1, l_we_n = 1'b1;
    logic [14:0] l_addr = '0;
    logic        r_ce_n = 1'b1, r_we_n = 1'b1;
    logic [14:0] r_addr = '0;
    logic        l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
    logic        l_busy_n, r_busy_n, l_arr_we_n, r_arr_we_n;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dpram_busy_arb u_dut (
        .clk(clk), .rst(rst), .master_mode(master_mode),
        .l_ce_n(l_ce_n), .l_we_n(l_we_n), .l_addr(l_addr),
        .r_ce_n(r_ce_n), .r_we_n(r_we_n), .r_addr(r_addr),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_arr_we_n(l_arr_we_n), .r_arr_we_n(r_arr_we_n)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic drive(input logic lce, input int la, input logic lwe,
                         input logic rce, input int ra, input logic rwe);
        @(negedge clk);
        l_ce_n = lce; l_addr = la[14:0]; l_we_n = lwe;
        r_ce_n = rce; r_addr = ra[14:0]; r_we_n = rwe;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R8: first cycle after reset, both arrive together, left wins
        @(negedge clk);
        rst = 1'b0;
        l_ce_n = 0; l_addr = 15'd9; l_we_n = 0;
        r_ce_n = 0; r_addr = 15'd9; r_we_n = 0;
        #1;
        chk("R8", "l_busy_n", l_busy_n, 1'b1);
        chk("R8", "r_busy_n", r_busy_n, 1'b0);
        chk("R8", "r_arr_we_n", r_arr_we_n, 1'b1);
        chk("R8", "l_arr_we_n", l_arr_we_n, 1'b0);

        // Sweep: idle, then both arrive in one cycle with writes
        for (int la = 0; la < 4; la++)
            for (int ra = 0; ra < 4; ra++)
                for (int ce = 0; ce < 4; ce++) begin
                    logic lce, rce, hit;
                    lce = ce[0]; rce = ce[1];
                    hit = !lce && !rce && (la == ra);
                    drive(1, 0, 1, 1, 0, 1);
                    drive(lce, la, 0, rce, ra, 0);
                    chk(hit ? "R4" : "R1", "l_busy_n", l_busy_n, 1'b1);
                    chk(hit ? "R4" : "R1", "r_busy_n", r_busy_n, !hit);
                    chk("R6", "l_arr_we_n", l_arr_we_n, 1'b0);
                    chk("R6", "r_arr_we_n", r_arr_we_n, hit);
                    chk("R3", "both low", !l_busy_n && !r_busy_n, 1'b0);
                end

        // R2: left settled first, right joins
        drive(1, 0, 1, 1, 0, 1);
        drive(0, 5, 1, 1, 0, 1);
        drive(0, 5, 1, 0, 5, 0);
        chk("R2", "r_busy_n", r_busy_n, 1'b0);
        chk("R2", "l_busy_n", l_busy_n, 1'b1);
        chk("R6", "r_arr_we_n", r_arr_we_n, 1'b1);
        // R5: hold while winner still, loser now settled
        drive(0, 5, 0, 0, 5, 0);
        chk("R5", "r_busy_n hold", r_busy_n, 1'b0);
        chk("R6", "l_arr_we_n pass", l_arr_we_n, 1'b0);
        drive(0, 5, 1, 0, 5, 0);
        chk("R5", "r_busy_n hold2", r_busy_n, 1'b0);
        // R5: winner releases
        drive(1, 5, 1, 0, 5, 0);
        chk("R5", "r_busy_n release", r_busy_n, 1'b1);
        chk("R5", "l_busy_n release", l_busy_n, 1'b1);
        chk("R6", "r_arr_we_n pass", r_arr_we_n, 1'b0);

        // R2: right settled first, left moves its address onto it
        drive(1, 0, 1, 1, 0, 1);
        drive(0, 2, 1, 0, 7, 1);
        drive(0, 7, 0, 0, 7, 1);
        chk("R2", "l_busy_n", l_busy_n, 1'b0);
        chk("R2", "r_busy_n", r_busy_n, 1'b1);
        chk("R6", "l_arr_we_n", l_arr_we_n, 1'b1);
        drive(0, 7, 0, 0, 7, 1);
        chk("R5", "l_busy_n hold", l_busy_n, 1'b0);
        // winner moves away: no collision
        drive(0, 7, 0, 0, 8, 1);
        chk("R1", "l_busy_n", l_busy_n, 1'b1);
        chk("R1", "r_busy_n", r_busy_n, 1'b1);
        chk("R6", "l_arr_we_n", l_arr_we_n, 1'b0);

        // R7: slave mode
        @(negedge clk);
        master_mode = 1'b0;
        drive(1, 0, 1, 1, 0, 1);
        drive(0, 3, 0, 0, 3, 0);
        chk("R7", "l_busy_n", l_busy_n, 1'b1);
        chk("R7", "r_busy_n", r_busy_n, 1'b1);
        chk("R7", "l_arr_we_n pass", l_arr_we_n, 1'b0);
        chk("R7", "r_arr_we_n pass", r_arr_we_n, 1'b0);
        @(negedge clk);
        l_busy_in_n = 1'b0;
        #1;
        chk("R7", "l_arr_we_n blocked", l_arr_we_n, 1'b1);
        chk("R7", "r_arr_we_n pass", r_arr_we_n, 1'b0);
        chk("R7", "l_busy_n", l_busy_n, 1'b1);
        @(negedge clk);
        l_busy_in_n = 1'b1; r_busy_in_n = 1'b0;
        #1;
        chk("R7", "r_arr_we_n blocked", r_arr_we_n, 1'b1);
        chk("R7", "l_arr_we_n pass", l_arr_we_n, 1'b0);
        chk("R7", "r_busy_n", r_busy_n, 1'b1);

        finish_run();
    end

endmodule